// File: doc/BRIEF.md
# Multi-port PHY-side cell bus slave

This block sits on the PHY side of an ATM cell bus and answers an external ATM-layer master. The bus has two independent directions. In the receive direction the block sends cells to the master. In the transmit direction it accepts cells from the master. Each direction carries an 8-bit byte lane, a 5-bit poll address, a start-of-cell flag, an active-low enable, a parity bit and a cell-available reply. Up to eight local ports sit behind the bus. The master finds out which port can move a cell by polling addresses. The block replies only to addresses that fall inside a programmed window, and reports for each port whether a receive cell is waiting and whether the transmit buffer still has room below a fill threshold.

A configuration bit chooses the addressing scheme. In multi-port mode a port is selected by its address: local port = address − window base. In single-port mode the address lanes are ignored and port 0 answers every poll. A cell is 53 bytes long. Each direction runs a small state machine with three states. ST_IDLE means no port is chosen. ST_ARMED means a port has been chosen by a poll while the enable was high. ST_BURST means a cell is in progress.

The transitions are:
- IDLE→ARMED and ARMED→ARMED: an in-window poll is seen while the enable is high.
- ARMED→BURST: the enable is low. On the transmit side the start-of-cell flag must also be high.
- BURST→BURST: each byte moves while the enable is low, and the state pauses while the enable is high.
- BURST→IDLE: the 53rd byte moves.

Top module: `cellbus_phy_slave`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both cell-available outputs and their output enables are 0, `tx_par_err` is 0, and `rx_buf_pop` and `tx_wr_valid` stay low while the enables are high.
- R2: In multi-port mode (`cfg_multi`=1), a poll address A is in the window when `cfg_addr_lo` ≤ A ≤ `cfg_addr_hi` and A − `cfg_addr_lo` < 8. For such an address, the cell-available output enable of that direction is 1 on the cycle after the address is sampled, and the polled port is A − `cfg_addr_lo`.
- R3: A poll address outside the window drives the cell-available output enable to 0 and cell-available to 0 on the next cycle.
- R4: Transmit cell-available for polled port p is 1 exactly when `tx_fill[p*8 +: 8]` ≤ `cfg_tx_thresh`.
- R5: In single-port mode (`cfg_multi`=0), the address inputs are ignored, the output enable is 1 on every cycle after reset, and port 0 is always the polled and selected port.
- R6: Receive cell-available for polled port p is `rx_rdy[p]`.
- R7: The port a cell moves through is the last in-window port polled while the enable was high before the cell started. An enable low with no such poll since the last cell moves nothing. The chosen port shows on `rx_buf_port` / `tx_wr_port`.
- R8: A cell is 53 byte transfers. The start-of-cell flag (`rx_soc`, `tx_wr_soc`) is 1 on the first byte only. After the 53rd byte the direction returns to idle and needs a new poll.
- R9: During a cell, the enable high pauses the transfer: no byte moves, the count holds, and polls do not change the chosen port.
- R10: A transmit cell begins only on a byte with `tx_soc`=1. Enable-low bytes seen before that are not written (`tx_wr_valid`=0). Each transmit byte moved appears on `tx_wr_data` in the same cycle.
- R11: `rx_data` carries `rx_buf_data`, and `rx_par` makes the 9-bit XOR of {`rx_data`, `rx_par`} equal to 1 (odd parity).
- R12: A transmit byte moved with an even 9-bit XOR of {`tx_data`, `tx_par`} sets `tx_par_err`, which then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_multi | input | 1 | 1 = multi-port addressing, 0 = single-port |
| cfg_addr_lo | input | 5 | Poll window base (maps to local port 0) |
| cfg_addr_hi | input | 5 | Poll window top (inclusive) |
| cfg_tx_thresh | input | 8 | Transmit fill threshold |
| rx_rdy | input | 8 | Per-port receive cell waiting |
| tx_fill | input | 64 | Per-port transmit fill, port p at bits p*8+:8 |
| rx_addr | input | 5 | Receive poll address |
| rx_enb_n | input | 1 | Receive enable, active low |
| rx_clav | output | 1 | Receive cell-available |
| rx_clav_oe | output | 1 | Drive enable for rx_clav (0 = high impedance) |
| rx_data | output | 8 | Receive byte lane |
| rx_soc | output | 1 | Receive start-of-cell |
| rx_par | output | 1 | Receive odd parity |
| rx_buf_data | input | 8 | Byte offered by the local receive buffer |
| rx_buf_pop | output | 1 | A receive byte is taken this cycle |
| rx_buf_port | output | 3 | Port the receive cell is taken from |
| tx_addr | input | 5 | Transmit poll address |
| tx_enb_n | input | 1 | Transmit enable, active low |
| tx_data | input | 8 | Transmit byte lane |
| tx_soc | input | 1 | Transmit start-of-cell |
| tx_par | input | 1 | Transmit parity |
| tx_clav | output | 1 | Transmit cell-available |
| tx_clav_oe | output | 1 | Drive enable for tx_clav |
| tx_wr_valid | output | 1 | A transmit byte is written this cycle |
| tx_wr_port | output | 3 | Port the transmit byte goes to |
| tx_wr_data | output | 8 | Transmit byte to the local buffer |
| tx_wr_soc | output | 1 | Written byte is the first of its cell |
| tx_par_err | output | 1 | Sticky transmit parity error |

## Verification
The bench sweeps the whole 5-bit address space against two windows, one of which runs past the eighth port. A decoder that ignored the port-count limit would answer addresses 28–31. A decoder that forgot the window would answer addresses below the base. It chooses a port and then polls an out-of-window address before the enable falls, and polls again during a pause in the middle of a cell. A design that latched the most recent address rather than the most recent in-window poll would send the cell to the wrong port. It also drives the enable low with no selection, holds the enable low past the 53rd byte, and offers transmit bytes before the start-of-cell flag. A byte counter that slipped, or a transfer that restarted, would write extra bytes or flag start-of-cell twice. Fill values that equal the threshold, sit one below it and sit one above it catch an off-by-one comparison.

// File: rtl/cellbus_pkg.sv
package cellbus_pkg;
    localparam int CELL_LEN_DEF = 53;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_BURST = 2'd2
    } cell_st_e;
endpackage

// File: rtl/cellbus_poll.sv
module cellbus_poll #(
    parameter int N_PORTS = 8,
    parameter int ADDR_W  = 5,
    localparam int PORT_W = $clog2(N_PORTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               multi,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [ADDR_W-1:0]  win_lo,
    input  logic [ADDR_W-1:0]  win_hi,
    input  logic [N_PORTS-1:0] status,
    output logic               hit,
    output logic [PORT_W-1:0]  idx,
    output logic               clav,
    output logic               clav_oe
);
    logic [ADDR_W-1:0] offs;
    logic              in_win;

    always_comb begin
        offs   = addr - win_lo;
        in_win = (addr >= win_lo) && (addr <= win_hi)
                 && ({1'b0, offs} < (ADDR_W+1)'(N_PORTS));
        hit    = multi ? in_win : 1'b1;
        idx    = multi ? offs[PORT_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clav    <= 1'b0;
            clav_oe <= 1'b0;
        end else begin
            clav_oe <= hit;
            clav    <= hit & status[idx];
        end
    end
endmodule

// File: rtl/cellbus_cell_fsm.sv
module cellbus_cell_fsm
    import cellbus_pkg::*;
#(
    parameter int N_PORTS  = 8,
    parameter int CELL_LEN = CELL_LEN_DEF,
    localparam int PORT_W  = $clog2(N_PORTS),
    localparam int CNT_W   = $clog2(CELL_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enb_n,
    input  logic              poll_hit,
    input  logic [PORT_W-1:0] poll_idx,
    input  logic              start_ok,
    output logic              fire,
    output logic              first,
    output logic [PORT_W-1:0] port
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CELL_LEN - 1);

    cell_st_e          st, st_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [PORT_W-1:0] sel, sel_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
            sel <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            sel <= sel_n;
        end
    end

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        sel_n = sel;
        fire  = 1'b0;
        unique case (st)
            ST_IDLE, ST_ARMED: begin
                if (!enb_n) begin
                    if (st == ST_ARMED && start_ok) begin
                        fire  = 1'b1;
                        cnt_n = CNT_W'(1);
                        st_n  = ST_BURST;
                    end
                end else if (poll_hit) begin
                    sel_n = poll_idx;
                    st_n  = ST_ARMED;
                end
            end
            ST_BURST: begin
                if (!enb_n) begin
                    fire = 1'b1;
                    if (cnt == LAST) begin
                        cnt_n = '0;
                        st_n  = ST_IDLE;
                    end else begin
                        cnt_n = cnt + CNT_W'(1);
                    end
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_comb begin
        first = fire && (cnt == '0);
        port  = sel;
    end
endmodule

// File: rtl/cellbus_phy_slave.sv
module cellbus_phy_slave
    import cellbus_pkg::*;
#(
    parameter int N_PORTS  = 8,
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 8,
    parameter int FILL_W   = 8,
    parameter int CELL_LEN = CELL_LEN_DEF,
    localparam int PORT_W  = $clog2(N_PORTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_multi,
    input  logic [ADDR_W-1:0]         cfg_addr_lo,
    input  logic [ADDR_W-1:0]         cfg_addr_hi,
    input  logic [FILL_W-1:0]         cfg_tx_thresh,
    input  logic [N_PORTS-1:0]        rx_rdy,
    input  logic [N_PORTS*FILL_W-1:0] tx_fill,
    input  logic [ADDR_W-1:0]         rx_addr,
    input  logic                      rx_enb_n,
    output logic                      rx_clav,
    output logic                      rx_clav_oe,
    output logic [DATA_W-1:0]         rx_data,
    output logic                      rx_soc,
    output logic                      rx_par,
    input  logic [DATA_W-1:0]         rx_buf_data,
    output logic                      rx_buf_pop,
    output logic [PORT_W-1:0]         rx_buf_port,
    input  logic [ADDR_W-1:0]         tx_addr,
    input  logic                      tx_enb_n,
    input  logic [DATA_W-1:0]         tx_data,
    input  logic                      tx_soc,
    input  logic                      tx_par,
    output logic                      tx_clav,
    output logic                      tx_clav_oe,
    output logic                      tx_wr_valid,
    output logic [PORT_W-1:0]         tx_wr_port,
    output logic [DATA_W-1:0]         tx_wr_data,
    output logic                      tx_wr_soc,
    output logic                      tx_par_err
);
    logic [N_PORTS-1:0] tx_room;
    logic               rx_hit, tx_hit;
    logic [PORT_W-1:0]  rx_idx, tx_idx;
    logic               rx_fire, tx_fire, rx_first, tx_first;
    logic               perr_q;

    for (genvar p = 0; p < N_PORTS; p++) begin : g_room
        assign tx_room[p] = tx_fill[p*FILL_W +: FILL_W] <= cfg_tx_thresh;
    end

    cellbus_poll #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W)) u_rx_poll (
        .clk(clk), .rst_n(rst_n), .multi(cfg_multi), .addr(rx_addr),
        .win_lo(cfg_addr_lo), .win_hi(cfg_addr_hi), .status(rx_rdy),
        .hit(rx_hit), .idx(rx_idx), .clav(rx_clav), .clav_oe(rx_clav_oe)
    );

    cellbus_poll #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W)) u_tx_poll (
        .clk(clk), .rst_n(rst_n), .multi(cfg_multi), .addr(tx_addr),
        .win_lo(cfg_addr_lo), .win_hi(cfg_addr_hi), .status(tx_room),
        .hit(tx_hit), .idx(tx_idx), .clav(tx_clav), .clav_oe(tx_clav_oe)
    );

    cellbus_cell_fsm #(.N_PORTS(N_PORTS), .CELL_LEN(CELL_LEN)) u_rx_fsm (
        .clk(clk), .rst_n(rst_n), .enb_n(rx_enb_n), .poll_hit(rx_hit),
        .poll_idx(rx_idx), .start_ok(1'b1), .fire(rx_fire),
        .first(rx_first), .port(rx_buf_port)
    );

    cellbus_cell_fsm #(.N_PORTS(N_PORTS), .CELL_LEN(CELL_LEN)) u_tx_fsm (
        .clk(clk), .rst_n(rst_n), .enb_n(tx_enb_n), .poll_hit(tx_hit),
        .poll_idx(tx_idx), .start_ok(tx_soc), .fire(tx_fire),
        .first(tx_first), .port(tx_wr_port)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perr_q <= 1'b0;
        end else if (tx_fire && !(^{tx_data, tx_par})) begin
            perr_q <= 1'b1;
        end
    end

    always_comb begin
        rx_data     = rx_buf_data;
        rx_par      = ~^rx_buf_data;
        rx_soc      = rx_first;
        rx_buf_pop  = rx_fire;
        tx_wr_valid = tx_fire;
        tx_wr_data  = tx_data;
        tx_wr_soc   = tx_first;
        tx_par_err  = perr_q;
    end
endmodule

// File: rtl/cellbus_phy_slave_chk.sv
module cellbus_phy_slave_chk #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    parameter int FILL_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_multi,
    input logic [ADDR_W-1:0] cfg_addr_lo,
    input logic [ADDR_W-1:0] cfg_addr_hi,
    input logic [FILL_W-1:0] cfg_tx_thresh,
    input logic [FILL_W-1:0] fill0,
    input logic              rdy0,
    input logic [ADDR_W-1:0] tx_addr,
    input logic              rx_enb_n,
    input logic              tx_enb_n,
    input logic              rx_clav,
    input logic              rx_clav_oe,
    input logic              tx_clav,
    input logic              tx_clav_oe,
    input logic              rx_soc,
    input logic              tx_wr_valid,
    input logic              tx_par_err,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_par
);
    AST_OUT_OF_WINDOW_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_multi && (tx_addr < cfg_addr_lo || tx_addr > cfg_addr_hi)) |=> (!tx_clav_oe && !tx_clav)); // R3

    AST_SINGLE_ALWAYS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_multi |=> rx_clav_oe); // R5

    AST_TX_OVER_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_multi && fill0 > cfg_tx_thresh) |=> !tx_clav); // R4

    AST_RX_NOTHING_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_multi && !rdy0) |=> !rx_clav); // R6

    AST_RX_SOC_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_soc |-> !rx_enb_n); // R8

    AST_TX_WRITE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr_valid |-> !tx_enb_n); // R10

    AST_PARITY_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_par_err |=> tx_par_err); // R12

    AST_RX_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        ^{rx_data, rx_par}); // R11
endmodule

bind cellbus_phy_slave cellbus_phy_slave_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FILL_W(FILL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_multi(cfg_multi),
    .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi),
    .cfg_tx_thresh(cfg_tx_thresh), .fill0(tx_fill[FILL_W-1:0]),
    .rdy0(rx_rdy[0]), .tx_addr(tx_addr), .rx_enb_n(rx_enb_n),
    .tx_enb_n(tx_enb_n), .rx_clav(rx_clav), .rx_clav_oe(rx_clav_oe),
    .tx_clav(tx_clav), .tx_clav_oe(tx_clav_oe), .rx_soc(rx_soc),
    .tx_wr_valid(tx_wr_valid), .tx_par_err(tx_par_err),
    .rx_data(rx_data), .rx_par(rx_par)
);

// File: tb/cellbus_phy_slave_test.sv
`timescale 1ns/1ps
module cellbus_phy_slave_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_multi = 1'b1;
    logic [4:0]  cfg_addr_lo = 5'd4, cfg_addr_hi = 5'd11;
    logic [7:0]  cfg_tx_thresh = 8'd100;
    logic [7:0]  rx_rdy = 8'b1011_0010;
    logic [63:0] tx_fill = '0;
    logic [4:0]  rx_addr = '0, tx_addr = '0;
    logic        rx_enb_n = 1'b1, tx_enb_n = 1'b1;
    logic [7:0]  rx_buf_data = '0, tx_data = '0;
    logic        tx_soc = 1'b0, tx_par = 1'b1;
    logic        rx_clav, rx_clav_oe, rx_soc, rx_par, rx_buf_pop;
    logic [7:0]  rx_data, tx_wr_data;
    logic [2:0]  rx_buf_port, tx_wr_port;
    logic        tx_clav, tx_clav_oe, tx_wr_valid, tx_wr_soc, tx_par_err;

    int  checks = 0, errs = 0;
    bit  done = 0;
    int  lfsr = 32'h1D2C_3B4A;

    always #4 clk = ~clk;

    cellbus_phy_slave uut (
        .clk(clk), .rst_n(rst_n), .cfg_multi(cfg_multi),
        .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi),
        .cfg_tx_thresh(cfg_tx_thresh), .rx_rdy(rx_rdy), .tx_fill(tx_fill),
        .rx_addr(rx_addr), .rx_enb_n(rx_enb_n), .rx_clav(rx_clav),
        .rx_clav_oe(rx_clav_oe), .rx_data(rx_data), .rx_soc(rx_soc),
        .rx_par(rx_par), .rx_buf_data(rx_buf_data), .rx_buf_pop(rx_buf_pop),
        .rx_buf_port(rx_buf_port), .tx_addr(tx_addr), .tx_enb_n(tx_enb_n),
        .tx_data(tx_data), .tx_soc(tx_soc), .tx_par(tx_par),
        .tx_clav(tx_clav), .tx_clav_oe(tx_clav_oe), .tx_wr_valid(tx_wr_valid),
        .tx_wr_port(tx_wr_port), .tx_wr_data(tx_wr_data),
        .tx_wr_soc(tx_wr_soc), .tx_par_err(tx_par_err)
    );

    // Behavioural reference: index 0 = receive, 1 = transmit
    bit m_oe[2], m_clav[2], m_selv[2], m_act[2], m_perr;
    int m_sel[2], m_cnt[2];

    function automatic int rnd8();
        lfsr = (lfsr << 1) ^ (((lfsr >>> 31) & 1) != 0 ? 32'h04C1_1DB7 : 0);
        return (lfsr >>> 7) & 255;
    endfunction

    function automatic void poll_of(input int a, output bit h, output int ix);
        if (!cfg_multi) begin
            h = 1; ix = 0;
        end else begin
            h  = (a >= cfg_addr_lo) && (a <= cfg_addr_hi) && (a - cfg_addr_lo < 8);
            ix = a - cfg_addr_lo;
        end
    endfunction

    function automatic bit fire_of(input int d);
        bit en_low = d ? !tx_enb_n : !rx_enb_n;
        bit ok     = d ? tx_soc : 1'b1;
        return en_low && (m_act[d] || (m_selv[d] && ok));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < 2; d++) begin
                m_oe[d] = 0; m_clav[d] = 0; m_selv[d] = 0; m_act[d] = 0;
                m_sel[d] = 0; m_cnt[d] = 0;
            end
            m_perr = 0;
        end else begin
            for (int d = 0; d < 2; d++) begin
                bit h, f, st, en_hi;
                int ix;
                poll_of(d ? int'(tx_addr) : int'(rx_addr), h, ix);
                st = h && (d ? (tx_fill[ix*8 +: 8] <= cfg_tx_thresh) : rx_rdy[ix]);
                f  = fire_of(d);
                en_hi = d ? tx_enb_n : rx_enb_n;
                m_oe[d] = h; m_clav[d] = st;
                if (f) begin
                    if (d == 1 && ((^{tx_data, tx_par}) == 1'b0)) m_perr = 1;
                    if (m_cnt[d] == 52) begin
                        m_act[d] = 0; m_selv[d] = 0; m_cnt[d] = 0;
                    end else begin
                        m_act[d] = 1; m_cnt[d]++;
                    end
                end else if (!m_act[d] && en_hi && h) begin
                    m_selv[d] = 1; m_sel[d] = ix;
                end
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_all();
        bit f0 = fire_of(0), f1 = fire_of(1);
        chk(cfg_multi ? "R2" : "R5", "rx_clav_oe", rx_clav_oe, m_oe[0]);
        chk("R6", "rx_clav", rx_clav, m_clav[0]);
        chk("R3", "tx_clav_oe", tx_clav_oe, m_oe[1]);
        chk("R4", "tx_clav", tx_clav, m_clav[1]);
        chk("R9", "rx_buf_pop", rx_buf_pop, f0);
        chk("R8", "rx_soc", rx_soc, f0 && m_cnt[0] == 0);
        chk("R11", "rx_parity", {31'd0, ^{rx_data, rx_par}} | {rx_data !== rx_buf_data, 1'b0}, 32'd1);
        chk("R10", "tx_wr_valid", tx_wr_valid, f1);
        chk("R12", "tx_par_err", tx_par_err, m_perr);
        if (f0) chk("R7", "rx_buf_port", rx_buf_port, m_sel[0]);
        if (f1) begin
            chk("R7", "tx_wr_port", tx_wr_port, m_sel[1]);
            chk("R10", "tx_wr_data", tx_wr_data, tx_data);
            chk("R8", "tx_wr_soc", tx_wr_soc, m_cnt[1] == 0);
        end
    endtask

    task automatic cyc();
        rx_buf_data = rnd8();
        #1 check_all();
        @(negedge clk);
    endtask

    task automatic sweep();
        for (int a = 0; a < 32; a++) begin
            rx_addr = a; tx_addr = 31 - a;
            cyc();
        end
    endtask

    task automatic tx_byte(input bit soc, input bit bad);
        tx_data = rnd8();
        tx_soc  = soc;
        tx_par  = bad ? ^tx_data : ~^tx_data;
    endtask

    initial begin
        tx_fill = {8'd150, 8'd99, 8'd255, 8'd0, 8'd200, 8'd101, 8'd100, 8'd50};
        @(negedge clk);
        cyc(); cyc();
        chk("R1", "reset clav_oe", {rx_clav_oe, tx_clav_oe}, 0);
        chk("R1", "reset clav", {rx_clav, tx_clav}, 0);
        rst_n = 1'b1;
        cyc();
        chk("R1", "after reset perr/pop", {tx_par_err, rx_buf_pop, tx_wr_valid}, 0);

        // R7: enable low with nothing chosen moves no byte
        rx_addr = 5'd0; tx_addr = 5'd31; rx_enb_n = 0; tx_enb_n = 0;
        tx_byte(1, 0);
        repeat (3) cyc();
        rx_enb_n = 1; tx_enb_n = 1;
        // R2 R3 R4 R6: window 4..11
        sweep();
        // R2 R3: window 20..31 clipped at eight ports
        cfg_addr_lo = 5'd20; cfg_addr_hi = 5'd31;
        sweep();
        cfg_addr_lo = 5'd4; cfg_addr_hi = 5'd11;

        // R7 R8 R9: receive cell to port 2
        rx_addr = 5'd6;  cyc();
        rx_addr = 5'd30; cyc();
        rx_enb_n = 0; rx_addr = 5'd9;
        repeat (20) cyc();
        rx_enb_n = 1; rx_addr = 5'd10;
        repeat (3) cyc();
        rx_enb_n = 0;
        repeat (40) cyc();
        rx_enb_n = 1;
        cyc();

        // R10 R12: transmit cell to port 5, bytes before start ignored
        tx_addr = 5'd9; cyc();
        tx_addr = 5'd0; tx_enb_n = 0;
        tx_byte(0, 0); cyc();
        tx_byte(0, 1); cyc();
        for (int b = 0; b < 53; b++) begin
            tx_byte(b == 0, b == 10);
            if (b == 30) begin
                tx_enb_n = 1; tx_addr = 5'd4; cyc(); cyc(); tx_enb_n = 0;
            end
            cyc();
        end
        tx_enb_n = 1;
        repeat (3) cyc();

        // R5: single-port mode, addresses ignored
        cfg_multi = 0;
        tx_fill[7:0] = 8'd100;
        for (int i = 0; i < 12; i++) begin
            rx_addr = rnd8(); tx_addr = rnd8();
            rx_rdy[0] = i[0];
            tx_fill[7:0] = 8'd99 + i[1:0];
            cyc();
        end
        chk("R5", "single oe", {rx_clav_oe, tx_clav_oe}, 2'b11);
        rx_enb_n = 0; tx_enb_n = 0;
        for (int b = 0; b < 56; b++) begin
            rx_addr = rnd8(); tx_addr = rnd8();
            tx_byte(b == 0, 0);
            cyc();
        end
        rx_enb_n = 1; tx_enb_n = 1;
        repeat (2) cyc();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule